// File: doc/BRIEF.md
# Parallel Bit-Reversal Reorder Buffer

This block sits behind a parallel pipelined radix-2 FFT that delivers P samples per clock in bit-reversed index order. It hands the same samples on, still P per clock, in natural index order. Symbols of N points follow each other without any idle cycle on either side. The block holds exactly N words of storage, split into two groups of P single-port banks. The two groups trade roles every clock cycle, never every symbol: one group takes the writes and the other serves the reads.

Incoming lanes pass through a write rotator that spreads the lanes of one cycle over all banks of a group. Each bank is written at a linear address during odd-numbered symbols of a burst. During even-numbered symbols it is written into the slot that the previous symbol's read has just freed. A read rotator and a group multiplexer put the banks back onto the output lanes. A small controller is built around four named states and derives every address, group select and rotation amount from one cycle counter and one symbol-parity bit.

The states are ST_IDLE, ST_FILL (first symbol of a burst, writes only until its last cycle), ST_STREAM (writes and reads every cycle) and ST_DRAIN (reads only, emptying the final symbol). The transitions are:
- **start**: ST_IDLE to ST_FILL, on in_valid.
- **fill_done**: ST_FILL to ST_STREAM, at the last cycle of the first symbol.
- **stop**: ST_STREAM to ST_DRAIN, when in_valid is low at a symbol's first cycle.
- **drained**: ST_DRAIN to ST_IDLE, after the last read.

The default parameters are P = 8 and N = 2·P² = 128. This gives 16 cycles per symbol and 8-word banks.

Top module: `fft_reorder_par`

## Requirements
- R1: In cycle t (0..2P-1) of a symbol, input lane p (bits [p*DW +: DW] of in_data) carries the point whose index is the bit reversal, over log2(N) bits, of t*P+p. In output cycle u of that symbol, lane q (bits [q*DW +: DW] of out_data) carries point u*P+q.
- R2: Count the clock edge that captures the first input cycle of a burst as edge 0. Output cycle u of symbol s is presented after edge 2P*s+2P+u, which is 17 cycles after the first input cycle for the defaults. Before that, out_valid is low.
- R3: For a burst of S back-to-back symbols, out_valid stays high for exactly 2P*S consecutive cycles with no gap.
- R4: No bank is ever read and written in the same clock cycle.
- R5: In input cycle t, lane p is stored in bank (p+s) mod P of its group. The shift s is the bit reversal of t>>1 over log2(P) bits, so s holds for each pair of cycles.
- R6: In every cycle where both a write and a read take place, they use opposite bank groups. The write group is t mod 2.
- R7: Every symbol after the first in a burst is reordered correctly. Its writes reuse the locations freed by reads of the symbol before it.
- R8: After reset, out_valid and out_data are 0. While idle, input data with in_valid low produces no output. A reset in the middle of a burst clears out_valid at once.
- R9: If in_valid is low in the first cycle of a symbol slot, the burst ends. The last symbol still comes out in full, and then out_valid falls. in_valid raised while that drain is in progress is ignored.
- R10: in_valid is examined only at a symbol's first cycle. Once a symbol has been accepted, all of its 2P cycles are taken as data even if in_valid is low in one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Starts or continues a burst when high at a symbol's first cycle |
| in_data | input | P*DW | P input lanes in bit-reversed order, lane p at [p*DW +: DW] |
| out_valid | output | 1 | Output lanes carry reordered data |
| out_data | output | P*DW | P output lanes in natural order, lane q at [q*DW +: DW] |

## Verification
The hardest case is the second and later symbols of a burst. A bank location there is rewritten in the cycle right after it is read, and the address pattern is the mirrored one. Only a burst of several back-to-back symbols reaches that state, and symbols of both parities must be checked. The stimulus table therefore runs bursts of one to five symbols, tags every sample with its symbol number and index, and compares all lanes on every output cycle. The boundary cases come from directed variations: in_valid dropped inside an accepted symbol, in_valid raised during a drain, and reset in the middle of a burst.

// File: rtl/fft_reorder_pkg.sv
package fft_reorder_pkg;

    // Controller states: idle, first-symbol fill, steady streaming, final drain.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_STREAM = 2'd2,
        ST_DRAIN  = 2'd3
    } reorder_state_e;

endpackage

// File: rtl/fft_reorder_bank.sv
// Single-port bank: one access per cycle, synchronous read.
module fft_reorder_bank #(
    parameter int DEPTH = 8,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end else if (re) begin
            rdata <= mem[addr];
        end
    end

    // R4: the single port is never asked for a read and a write together
    p_single_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && re));

endmodule

// File: rtl/fft_reorder_rotate.sv
// Lane rotator: DOWN=1 gives out[k] = in[k - s], DOWN=0 gives out[k] = in[k + s] (mod P).
module fft_reorder_rotate #(
    parameter int P    = 8,
    parameter int DW   = 16,
    parameter bit DOWN = 1'b1,
    localparam int PW  = $clog2(P)
) (
    input  logic [P*DW-1:0] din,
    input  logic [PW-1:0]   shift,
    output logic [P*DW-1:0] dout
);

    for (genvar k = 0; k < P; k++) begin : g_lane
        logic [PW-1:0] src;
        if (DOWN) begin : g_down
            assign src = PW'(k) - shift;
        end else begin : g_up
            assign src = PW'(k) + shift;
        end
        assign dout[k*DW +: DW] = din[int'(src)*DW +: DW];
    end

endmodule

// File: rtl/fft_reorder_ctrl.sv
// Controller: one cycle counter plus a symbol-parity bit drive every select.
module fft_reorder_ctrl
    import fft_reorder_pkg::*;
#(
    parameter int P   = 8,
    localparam int PW = $clog2(P)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          wr_en,
    output logic          wr_grp,
    output logic [PW-1:0] wr_slot,
    output logic [PW-1:0] wr_rot,
    output logic          wr_even,
    output logic          rd_en,
    output logic          rd_grp,
    output logic [PW-1:0] rd_slot,
    output logic [PW-1:0] rd_rot,
    output logic          rd_even
);

    localparam int CW = PW + 1;
    localparam int C  = 1 << CW;
    localparam logic [CW-1:0] CNT_LAST      = CW'(C - 1);
    localparam logic [CW-1:0] CNT_DRAIN_END = CW'(C - 2);

    function automatic logic [PW-1:0] rev_bits(input logic [PW-1:0] x);
        logic [PW-1:0] r;
        for (int i = 0; i < PW; i++) r[i] = x[PW-1-i];
        return r;
    endfunction

    reorder_state_e state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           even_q, even_d;
    logic [CW-1:0]  rd_pos;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            even_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            even_q  <= even_d;
        end
    end

    // Next state, counter and parity
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + CW'(1);
        even_d  = even_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d  = '0;
                even_d = 1'b0;
                if (in_valid) begin
                    state_d = ST_FILL;
                    cnt_d   = CW'(1);
                end
            end
            ST_FILL: begin
                if (cnt_q == CNT_LAST) begin
                    state_d = ST_STREAM;
                    even_d  = ~even_q;
                end
            end
            ST_STREAM: begin
                if (cnt_q == CNT_LAST) begin
                    even_d = ~even_q;
                end else if (cnt_q == '0 && !in_valid) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (cnt_q == CNT_DRAIN_END) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        wr_en = 1'b0;
        rd_en = 1'b0;
        unique case (state_q)
            ST_IDLE:   wr_en = in_valid;
            ST_FILL: begin
                wr_en = 1'b1;
                rd_en = (cnt_q == CNT_LAST);
            end
            ST_STREAM: begin
                wr_en = (cnt_q != '0) || in_valid;
                rd_en = 1'b1;
            end
            ST_DRAIN:  rd_en = 1'b1;
            default: begin
                wr_en = 1'b0;
                rd_en = 1'b0;
            end
        endcase
    end

    assign wr_grp  = cnt_q[0];
    assign wr_slot = cnt_q[CW-1:1];
    assign wr_rot  = rev_bits(wr_slot);
    assign wr_even = even_q;

    // Reads run one cycle ahead of the write position, on the other group.
    assign rd_pos  = cnt_q + CW'(1);
    assign rd_grp  = rd_pos[0];
    assign rd_slot = rd_pos[CW-1:1];
    assign rd_rot  = rev_bits(rd_slot);
    assign rd_even = (cnt_q == CNT_LAST) ? even_q : ~even_q;

    // R3: once reading starts it continues every cycle until the drain ends
    p_read_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !(state_q == ST_DRAIN && cnt_q == CNT_DRAIN_END)) |=> rd_en);

    // R6: a write and a read in the same cycle never share a group
    p_groups_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en) |-> (wr_grp != rd_grp));

    // R5: the write rotation holds for both cycles of a pair
    p_pattern_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_grp && $past(wr_en)) |-> (wr_rot == $past(wr_rot)));

endmodule

// File: rtl/fft_reorder_par.sv
// Top: write rotator, two groups of single-port banks, group mux, read rotator.
module fft_reorder_par #(
    parameter int P  = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [P*DW-1:0] in_data,
    output logic          out_valid,
    output logic [P*DW-1:0] out_data
);

    localparam int PW    = $clog2(P);
    localparam int DEPTH = P;            // N/(2P) with N = 2*P*P
    localparam int NGRP  = 2;

    function automatic logic [PW-1:0] rev_bits(input logic [PW-1:0] x);
        logic [PW-1:0] r;
        for (int i = 0; i < PW; i++) r[i] = x[PW-1-i];
        return r;
    endfunction

    logic          wr_en, wr_grp, wr_even;
    logic          rd_en, rd_grp, rd_even;
    logic [PW-1:0] wr_slot, wr_rot, rd_slot, rd_rot;

    fft_reorder_ctrl #(.P(P)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .wr_en   (wr_en),
        .wr_grp  (wr_grp),
        .wr_slot (wr_slot),
        .wr_rot  (wr_rot),
        .wr_even (wr_even),
        .rd_en   (rd_en),
        .rd_grp  (rd_grp),
        .rd_slot (rd_slot),
        .rd_rot  (rd_rot),
        .rd_even (rd_even)
    );

    logic [P*DW-1:0] bank_wdata;

    fft_reorder_rotate #(.P(P), .DW(DW), .DOWN(1'b1)) u_wr_rot (
        .din  (in_data),
        .shift(wr_rot),
        .dout (bank_wdata)
    );

    logic [PW-1:0] bank_waddr [P];
    logic [PW-1:0] bank_raddr [P];
    logic [DW-1:0] bank_q     [NGRP][P];

    for (genvar b = 0; b < P; b++) begin : g_bank
        // Slot freed by the partner read: reverse of (bank - shift) mod P
        assign bank_waddr[b] = wr_even ? rev_bits(PW'(b) - wr_rot) : wr_slot;
        assign bank_raddr[b] = rd_even ? rd_slot : rev_bits(PW'(b) - rd_rot);

        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            logic          we_g, re_g;
            logic [PW-1:0] addr_g;
            assign we_g   = wr_en && (wr_grp == 1'(g));
            assign re_g   = rd_en && (rd_grp == 1'(g));
            assign addr_g = we_g ? bank_waddr[b] : bank_raddr[b];

            fft_reorder_bank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
                .clk  (clk),
                .rst_n(rst_n),
                .we   (we_g),
                .re   (re_g),
                .addr (addr_g),
                .wdata(bank_wdata[b*DW +: DW]),
                .rdata(bank_q[g][b])
            );
        end
    end

    // Read-side alignment with the synchronous bank read
    logic          rd_v1, rd_grp1;
    logic [PW-1:0] rd_rot1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_v1   <= 1'b0;
            rd_grp1 <= 1'b0;
            rd_rot1 <= '0;
        end else begin
            rd_v1   <= rd_en;
            rd_grp1 <= rd_grp;
            rd_rot1 <= rd_rot;
        end
    end

    logic [P*DW-1:0] grp_sel, lane_out;

    always_comb begin
        for (int b = 0; b < P; b++) begin
            grp_sel[b*DW +: DW] = rd_grp1 ? bank_q[1][b] : bank_q[0][b];
        end
    end

    fft_reorder_rotate #(.P(P), .DW(DW), .DOWN(1'b0)) u_rd_rot (
        .din  (grp_sel),
        .shift(rd_rot1),
        .dout (lane_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= rd_v1;
            if (rd_v1) begin
                out_data <= lane_out;
            end
        end
    end

endmodule

// File: tb/tb_fft_reorder_par.sv
`timescale 1ns/1ps
module tb_fft_reorder_par;

    localparam int P    = 8;
    localparam int DW   = 16;
    localparam int PW   = $clog2(P);
    localparam int C    = 2 * P;
    localparam int LOGN = 2 * PW + 1;
    localparam int LAT  = C + 1;
    localparam int NB   = 4;

    // Stimulus table: symbols per burst, dropped-valid symbol/cycle, drain injection
    localparam int T_SYM  [NB] = '{5, 1, 3, 4};
    localparam int T_DSYM [NB] = '{-1, -1, 1, 2};
    localparam int T_DCYC [NB] = '{0, 0, 7, 15};
    localparam int T_INJ  [NB] = '{0, 1, 0, 1};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [P*DW-1:0] in_data = '0;
    logic            out_valid;
    logic [P*DW-1:0] out_data;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    fft_reorder_par #(.P(P), .DW(DW)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_data (out_data)
    );

    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] tag_word(int sym, int idx);
        return {8'(sym), 8'(idx)};
    endfunction

    // R1 input order: lane p of cycle t holds point bitrev(t*P+p)
    function automatic int in_index(int t, int p);
        logic [LOGN-1:0] j, r;
        j = LOGN'(t * P + p);
        for (int i = 0; i < LOGN; i++) r[i] = j[LOGN-1-i];
        return int'(r);
    endfunction

    task automatic put_cycle(int sym, int t, bit v);
        in_valid = v;
        for (int p = 0; p < P; p++) in_data[p*DW +: DW] = tag_word(sym, in_index(t, p));
    endtask

    task automatic chk_bit(string rq, logic act, logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: out_valid=%0b expected %0b at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic chk_lanes(string rq, int sym, int u);
        bit bad = 1'b0;
        nchk++;
        for (int q = 0; q < P; q++) begin
            if (!bad && out_data[q*DW +: DW] !== tag_word(sym, u * P + q)) begin
                bad = 1'b1;
                nerr++;
                $display("FAIL %s: lane %0d out=%h expected %h (symbol tag %0d cycle %0d)",
                         rq, q, out_data[q*DW +: DW], tag_word(sym, u * P + q), sym, u);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    endtask

    // Called on a falling edge; drives a burst and checks every output cycle.
    task automatic run_burst(int nsym, int dsym, int dcyc, int inj, int tbase);
        fork
            begin
                for (int s = 0; s < nsym; s++) begin
                    for (int t = 0; t < C; t++) begin
                        put_cycle(tbase + s, t, !(s == dsym && t == dcyc));
                        @(negedge clk);
                    end
                end
                in_valid = 1'b0;
                if (inj != 0) begin
                    // R9: valid raised while the burst drains must be ignored
                    @(negedge clk);
                    @(negedge clk);
                    for (int k = 0; k < 10; k++) begin
                        put_cycle(8'hEE, k, 1'b1);
                        @(negedge clk);
                    end
                    in_valid = 1'b0;
                end
            end
            begin
                for (int n = 0; n < LAT + C * nsym + 4; n++) begin
                    bit    exp_v;
                    string rq;
                    exp_v = (n >= LAT) && (n < LAT + C * nsym);
                    if (n <= LAT)               rq = "R2";
                    else if (exp_v)             rq = "R3";
                    else                        rq = "R9";
                    chk_bit(rq, out_valid, exp_v);
                    if (exp_v) begin
                        int s, u;
                        s = (n - LAT) / C;
                        u = (n - LAT) % C;
                        if (s == dsym)     rq = "R10";
                        else if (s == 0)   rq = "R1 R4 R5 R6";
                        else               rq = "R7 R4 R5 R6";
                        chk_lanes(rq, tbase + s, u);
                    end
                    @(negedge clk);
                end
            end
        join
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: run did not complete, actual hang expected finish");
        finish_run();
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        chk_bit("R8", out_valid, 1'b0);
        nchk++;
        if (out_data !== '0) begin
            nerr++;
            $display("FAIL R8: out_data=%h expected 0", out_data);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R8: junk on the data lanes with valid low produces nothing
        in_data = {P{16'hA5C3}};
        for (int k = 0; k < 25; k++) begin
            chk_bit("R8", out_valid, 1'b0);
            @(negedge clk);
        end

        // Table walk
        for (int b = 0; b < NB; b++) begin
            run_burst(T_SYM[b], T_DSYM[b], T_DCYC[b], T_INJ[b], 16 * b + 1);
            for (int k = 0; k < 30; k++) begin
                chk_bit("R9", out_valid, 1'b0);
                @(negedge clk);
            end
        end

        // R8: reset in the middle of a burst
        for (int k = 0; k < 24; k++) begin
            put_cycle(8'h60 + k / C, k % C, 1'b1);
            @(negedge clk);
        end
        rst_n    = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        chk_bit("R8", out_valid, 1'b0);
        rst_n = 1'b1;
        for (int k = 0; k < 20; k++) begin
            chk_bit("R8", out_valid, 1'b0);
            @(negedge clk);
        end

        // Fresh burst after the reset restarts in the linear layout
        run_burst(2, -1, 0, 0, 8'h70);
        repeat (4) @(negedge clk);

        finish_run();
    end

endmodule